// File: doc/BRIEF.md
# Banked Address Generator

This unit produces the 24-bit bus address for each cycle of a 16-bit processor core whose memory space is split into 256 banks of 64 KB. It keeps three registers of its own: a program bank, a data bank and a 16-bit direct-page base. On each cycle the core presents a cycle class, a 16-bit offset, an index value, the stack pointer, the program counter and an operand bank. One clock later the unit drives the resulting address together with two bus qualifiers: one marking program-stream fetches and one marking data transfers.

Program fetches and ordinary data accesses are placed in the bank held by the matching register, so code and data can sit in different banks. Direct-page and stack traffic is always confined to bank zero. Long-mode accesses carry their own bank byte in the operand and bypass the data bank. The core loads the registers through separate strobes that share one data bus.

Top module: `bank_addr_unit`

## Requirements
- R1: After reset the address output is 0x000000, both qualifiers are low, and the program bank, data bank and direct base all read as zero through later requests.
- R2: Cycle class codes on `mode` are 0 internal, 1 program fetch, 2 absolute, 3 absolute indexed, 4 direct, 5 direct indexed, 6 stack, 7 long. The request is captured at a rising edge and its address and qualifiers appear after that edge. Registers in effect before that edge are used, so a load at the same edge is not yet visible.
- R3: A program fetch drives {program bank, pc}, raises `prog_valid` and lowers `data_valid`.
- R4: An absolute access drives {data bank, offset}, raises `data_valid` and lowers `prog_valid`.
- R5: An absolute indexed access drives the 24-bit sum of {data bank, offset} and the zero-extended index. A carry out of bit 15 increments the bank byte, and the sum wraps modulo 2^24.
- R6: A direct access drives bank 0x00 with the low 16 bits of direct base plus offset[7:0]. Offset bits 15:8 are ignored, and the sum wraps inside bank 0x00.
- R7: A direct indexed access drives bank 0x00 with the low 16 bits of direct base + offset[7:0] + index, never carrying into bit 16.
- R8: A stack access drives {0x00, sp} with `data_valid` high.
- R9: A long access drives {long_bank, offset} with `data_valid` high, whatever the data bank holds.
- R10: An internal cycle lowers both qualifiers and leaves the address output unchanged.
- R11: `pbank_ld` and `dbank_ld` load ld_data[7:0], ignoring ld_data[15:8]. `dreg_ld` loads all 16 bits. A register with no strobe keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pbank_ld | input | 1 | Load program bank from ld_data[7:0] |
| dbank_ld | input | 1 | Load data bank from ld_data[7:0] |
| dreg_ld | input | 1 | Load direct base from ld_data |
| ld_data | input | 16 | Shared load value |
| mode | input | 3 | Cycle class code |
| pc | input | 16 | Program counter |
| offset | input | 16 | Operand offset |
| index | input | 16 | Index register value |
| sp | input | 16 | Stack pointer |
| long_bank | input | 8 | Bank byte from a long operand |
| addr | output | 24 | Registered bus address |
| prog_valid | output | 1 | Program-stream fetch qualifier |
| data_valid | output | 1 | Data transfer qualifier |

## Verification
The bench builds the unit with its default widths: an 8-bit bank, a 16-bit word and an 8-bit direct offset. These widths make two wraps reachable with short vectors. One is the carry from 0xFFFF into the bank byte, which rolls over at 0xFFFFFF. The other is the direct-page sum crossing 0xFFFF, which must fold back into bank zero. The same widths let bench values in the upper byte of `ld_data` and of `offset` show that those bits are dropped.

// File: rtl/bank_addr_unit.sv
module bank_addr_unit #(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16,
  parameter int DP_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pbank_ld,
  input  logic                      dbank_ld,
  input  logic                      dreg_ld,
  input  logic [WORD_W-1:0]         ld_data,
  input  logic [2:0]                mode,
  input  logic [WORD_W-1:0]         pc,
  input  logic [WORD_W-1:0]         offset,
  input  logic [WORD_W-1:0]         index,
  input  logic [WORD_W-1:0]         sp,
  input  logic [BANK_W-1:0]         long_bank,
  output logic [BANK_W+WORD_W-1:0]  addr,
  output logic                      prog_valid,
  output logic                      data_valid
);
  localparam int ADDR_W = BANK_W + WORD_W;
  localparam logic [2:0] M_INT  = 3'd0;
  localparam logic [2:0] M_PROG = 3'd1;
  localparam logic [2:0] M_ABS  = 3'd2;
  localparam logic [2:0] M_ABSX = 3'd3;
  localparam logic [2:0] M_DIR  = 3'd4;
  localparam logic [2:0] M_DIRX = 3'd5;
  localparam logic [2:0] M_STK  = 3'd6;
  localparam logic [2:0] M_LONG = 3'd7;
  localparam logic [BANK_W-1:0] BANK0 = '0;

  logic [BANK_W-1:0] pbank_q, dbank_q;
  logic [WORD_W-1:0] dreg_q;

  logic [WORD_W-1:0] dp_ofs, dp_sum, dpx_sum;
  logic [ADDR_W-1:0] abs_addr, absx_addr;
  logic [ADDR_W-1:0] addr_nxt;
  logic              pv_nxt, dv_nxt;

  assign dp_ofs    = WORD_W'(offset[DP_W-1:0]);
  assign dp_sum    = dreg_q + dp_ofs;
  assign dpx_sum   = dp_sum + index;
  assign abs_addr  = {dbank_q, offset};
  assign absx_addr = abs_addr + ADDR_W'(index);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbank_q <= '0;
      dbank_q <= '0;
      dreg_q  <= '0;
    end else begin
      if (pbank_ld) pbank_q <= ld_data[BANK_W-1:0];
      if (dbank_ld) dbank_q <= ld_data[BANK_W-1:0];
      if (dreg_ld)  dreg_q  <= ld_data;
    end
  end

  always_comb begin
    addr_nxt = addr;
    pv_nxt   = 1'b0;
    dv_nxt   = 1'b1;
    case (mode)
      M_PROG: begin addr_nxt = {pbank_q, pc}; pv_nxt = 1'b1; dv_nxt = 1'b0; end
      M_ABS:  addr_nxt = abs_addr;
      M_ABSX: addr_nxt = absx_addr;
      M_DIR:  addr_nxt = {BANK0, dp_sum};
      M_DIRX: addr_nxt = {BANK0, dpx_sum};
      M_STK:  addr_nxt = {BANK0, sp};
      M_LONG: addr_nxt = {long_bank, offset};
      default: dv_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr       <= '0;
      prog_valid <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      addr       <= addr_nxt;
      prog_valid <= pv_nxt;
      data_valid <= dv_nxt;
    end
  end
endmodule

// File: rtl/bank_addr_unit_chk.sv
module bank_addr_unit_chk #(
  parameter int BANK_W = 8,
  parameter int WORD_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dbank_ld,
  input logic                     pbank_ld,
  input logic [2:0]               mode,
  input logic [WORD_W-1:0]        pc,
  input logic [WORD_W-1:0]        offset,
  input logic [WORD_W-1:0]        sp,
  input logic [BANK_W-1:0]        long_bank,
  input logic [BANK_W-1:0]        pbank_q,
  input logic [BANK_W-1:0]        dbank_q,
  input logic [BANK_W+WORD_W-1:0] addr,
  input logic                     prog_valid,
  input logic                     data_valid
);
  localparam logic [BANK_W-1:0] Z = '0;

  AST_QUAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(prog_valid && data_valid)); // R2
  AST_PROG_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd1) |=> (prog_valid && !data_valid && addr == {$past(pbank_q), $past(pc)})); // R3
  AST_DIRECT_BANK0: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd4 || mode == 3'd5) |=> (data_valid && addr[BANK_W+WORD_W-1:WORD_W] == Z)); // R6
  AST_STACK_BANK0: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd6) |=> (data_valid && addr == {Z, $past(sp)})); // R8
  AST_LONG_OWN_BANK: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd7) |=> (addr == {$past(long_bank), $past(offset)})); // R9
  AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (mode == 3'd0) |=> (!prog_valid && !data_valid && $stable(addr))); // R10
  AST_DBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !dbank_ld |=> $stable(dbank_q)); // R11
  AST_PBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !pbank_ld |=> $stable(pbank_q)); // R11
endmodule

bind bank_addr_unit bank_addr_unit_chk #(.BANK_W(BANK_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbank_ld(dbank_ld), .pbank_ld(pbank_ld),
  .mode(mode), .pc(pc), .offset(offset), .sp(sp), .long_bank(long_bank),
  .pbank_q(pbank_q), .dbank_q(dbank_q), .addr(addr),
  .prog_valid(prog_valid), .data_valid(data_valid)
);

// File: tb/test_bank_addr_unit.sv
module test_bank_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pbank_ld = 1'b0, dbank_ld = 1'b0, dreg_ld = 1'b0;
  logic [15:0] ld_data = '0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] pc = '0, offset = '0, index = '0, sp = '0;
  logic [7:0]  long_bank = '0;
  logic [23:0] addr;
  logic        prog_valid, data_valid;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  bank_addr_unit i_bank_addr_unit (
    .clk(clk), .rst_n(rst_n), .pbank_ld(pbank_ld), .dbank_ld(dbank_ld),
    .dreg_ld(dreg_ld), .ld_data(ld_data), .mode(mode), .pc(pc),
    .offset(offset), .index(index), .sp(sp), .long_bank(long_bank),
    .addr(addr), .prog_valid(prog_valid), .data_valid(data_valid)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic chk_q(input string tag, input logic pv, input logic dv);
    chk(tag, {22'd0, prog_valid, data_valid}, {22'd0, pv, dv});
  endtask

  task automatic step(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    @(posedge clk);
    #1;
    pbank_ld = 1'b0; dbank_ld = 1'b0; dreg_ld = 1'b0;
  endtask

  task automatic load(input logic pl, input logic dl, input logic rl, input logic [15:0] v);
    @(negedge clk);
    pbank_ld = pl; dbank_ld = dl; dreg_ld = rl; ld_data = v; mode = 3'd0;
    @(posedge clk);
    #1;
    pbank_ld = 1'b0; dbank_ld = 1'b0; dreg_ld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 addr", addr, 24'h000000);
    chk_q("R1 qual", 1'b0, 1'b0);
    rst_n = 1'b1;
    pc = 16'h1234; step(3'd1);
    chk("R1 pbank zero", addr, 24'h001234);
    offset = 16'h5678; step(3'd2);
    chk("R1 dbank zero", addr, 24'h005678);
    offset = 16'h0042; step(3'd4);
    chk("R1 dreg zero", addr, 24'h000042);
  endtask

  task automatic t_prog;
    load(1'b1, 1'b0, 1'b0, 16'h12A5);
    pc = 16'hBEEF; step(3'd1);
    chk("R3/R11 prog addr", addr, 24'hA5BEEF);
    chk_q("R3 qual", 1'b1, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    dbank_ld = 1'b1; ld_data = 16'h0033; offset = 16'h0100; mode = 3'd2;
    @(posedge clk); #1;
    dbank_ld = 1'b0;
    chk("R2 old bank used", addr, 24'h000100);
    step(3'd2);
    chk("R2 new bank next", addr, 24'h330100);
  endtask

  task automatic t_abs;
    load(1'b0, 1'b1, 1'b0, 16'h007E);
    offset = 16'h1000; step(3'd2);
    chk("R4 abs addr", addr, 24'h7E1000);
    chk_q("R4 qual", 1'b0, 1'b1);
    ld_data = 16'h0099; step(3'd2);
    chk("R11 hold without strobe", addr, 24'h7E1000);
  endtask

  task automatic t_absx;
    offset = 16'hFFF0; index = 16'h0020; step(3'd3);
    chk("R5 carry into bank", addr, 24'h7F0010);
    load(1'b0, 1'b1, 1'b0, 16'h00FF);
    offset = 16'hFFFF; index = 16'h0001; step(3'd3);
    chk("R5 wrap 24 bit", addr, 24'h000000);
  endtask

  task automatic t_direct;
    load(1'b0, 1'b0, 1'b1, 16'hFFF0);
    offset = 16'hAB20; step(3'd4);
    chk("R6 direct wrap", addr, 24'h000010);
    chk_q("R6 qual", 1'b0, 1'b1);
  endtask

  task automatic t_dirx;
    load(1'b0, 1'b0, 1'b1, 16'h1000);
    offset = 16'h0005; index = 16'hF000; step(3'd5);
    chk("R7 direct idx wrap", addr, 24'h000005);
  endtask

  task automatic t_stack;
    sp = 16'h01FF; step(3'd6);
    chk("R8 stack", addr, 24'h0001FF);
    chk_q("R8 qual", 1'b0, 1'b1);
  endtask

  task automatic t_long;
    long_bank = 8'h40; offset = 16'h2222; step(3'd7);
    chk("R9 long", addr, 24'h402222);
  endtask

  task automatic t_internal;
    long_bank = 8'h11; offset = 16'h9999; pc = 16'h7777; step(3'd0);
    chk("R10 addr held", addr, 24'h402222);
    chk_q("R10 qual", 1'b0, 1'b0);
  endtask

  initial begin
    #1;
    t_reset;
    t_prog;
    t_latency;
    t_abs;
    t_absx;
    t_direct;
    t_dirx;
    t_stack;
    t_long;
    t_internal;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule